// File: doc/BRIEF.md
# Free-Running Timer with Output Compare

This block holds a 16-bit up-counter that never stops and a compare unit that watches it. A fixed prescaler moves the counter forward by one count every four clocks. When the count reaches a programmed 16-bit compare value, the block raises a status flag and loads a programmed level onto its compare output pin. It can also request an interrupt. Software sees the block as six byte-wide registers on a simple strobe bus. Reads are combinational within the strobe cycle. Writes take effect at the clock edge that ends the strobe cycle.

The compare value is loaded one byte at a time. Writing the high byte suspends matching until the low byte follows, so a half-written value can never produce a false match. Clearing the flag takes two steps: a status read that sees the flag set, then a compare low-byte write. Reading the counter high byte freezes a copy of the low byte, so a two-byte read of a moving counter stays consistent.

Top module: `cmp_timer`

## Requirements
- R1: The counter resets to 16'hFFFC, advances by exactly one every 4 clocks, and wraps from 16'hFFFF to 16'h0000.
- R2: The compare high byte (address 2) and low byte (address 3) read back what was last written to them. Writing one byte leaves the other unchanged, and neither byte is changed by reset or by the counter.
- R3: A match occurs in the first clock in which the counter holds a new value equal to the compare value. At the next edge, a match sets the flag (status bit 6, address 1) and copies control bit 0 onto cmp_out. cmp_out resets to 0 and changes at no other time.
- R4: A write to the compare high byte blocks all matches until the next compare low-byte write. Matching is also blocked from reset until the first low-byte write.
- R5: A compare low-byte write that is not preceded by a high-byte write leaves matching enabled.
- R6: irq is high exactly while the flag is set and control bit 7 (interrupt enable) is set.
- R7: A match copies control bit 0 onto cmp_out even when the flag is already set.
- R8: The flag clears only at a compare low-byte write that follows a status read in which the flag was set. A low-byte write with no such read leaves the flag set, and reset does not clear it.
- R9: A given count value produces at most one match, even if the flag is cleared and the compare value is rewritten while the counter still holds that value.
- R10: Reading the counter high byte (address 4) saves the current low byte. The next low-byte read (address 5) returns that saved byte, however many clocks later it occurs.
- R11: The control register (address 0) reads back bits 7 and 0 with all other bits as 0. Unused status bits and unmapped addresses read 0. bus_rdata is 0 when bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe |
| cmp_out | output | 1 | Compare output level |
| irq | output | 1 | Compare interrupt request, active high |

## Verification
The bench times two successive matches to the exact clock. A prescaler or counter that is off by one shifts that interval away from 64 clocks. The bench then clears the flag and rewrites the same compare value while the count has not yet moved. A compare that runs every clock instead of once per count sets the flag again, and the status read that follows shows it.

Several other faults are also targeted:
- A high-byte write that does not block matching lets the pin rise during the blocked window.
- A low-byte write that clears the flag without the preceding status read drops the interrupt.
- A flag that gates the level transfer leaves the pin high on the second match.
- A counter whose low byte is not held on a high-byte read returns a later count.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int unsigned BUS_AW   = 3;
  localparam int unsigned CNT_W    = 16;
  localparam logic [CNT_W-1:0] CNT_RST = 16'hFFFC;

  localparam logic [BUS_AW-1:0] ADR_CTRL = 3'd0;
  localparam logic [BUS_AW-1:0] ADR_STAT = 3'd1;
  localparam logic [BUS_AW-1:0] ADR_CMPH = 3'd2;
  localparam logic [BUS_AW-1:0] ADR_CMPL = 3'd3;
  localparam logic [BUS_AW-1:0] ADR_CNTH = 3'd4;
  localparam logic [BUS_AW-1:0] ADR_CNTL = 3'd5;

  localparam int unsigned CTRL_LVL_BIT  = 0;
  localparam int unsigned CTRL_IE_BIT   = 7;
  localparam int unsigned STAT_FLAG_BIT = 6;

  typedef struct packed {
    logic wr_ctrl;
    logic rd_stat;
    logic wr_cmp_hi;
    logic wr_cmp_lo;
    logic rd_cnt_hi;
    logic rd_cnt_lo;
  } bus_evt_t;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic cnt_hit(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] v);
    return c == v;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [CNT_W-1:0] cnt,
  output logic             fresh,
  output logic [7:0]       lo_view
);
  logic [CNT_W-1:0] cnt_q;
  logic             fresh_q;
  logic [7:0]       lo_buf_q;
  logic             held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_RST;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= tick;
      if (tick) cnt_q <= cnt_next(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_buf_q <= '0;
      held_q   <= 1'b0;
    end else if (rd_hi) begin
      lo_buf_q <= cnt_q[7:0];
      held_q   <= 1'b1;
    end else if (rd_lo) begin
      held_q   <= 1'b0;
    end
  end

  assign cnt     = cnt_q;
  assign fresh   = fresh_q;
  assign lo_view = held_q ? lo_buf_q : cnt_q[7:0];
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fresh,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wdata,
  input  logic             rd_stat,
  input  logic             lvl_sel,
  output logic [CNT_W-1:0] cmp_val,
  output logic             flag,
  output logic             pin,
  output logic             inhibit,
  output logic             match_evt
);
  logic [7:0] cmp_hi_q;
  logic [7:0] cmp_lo_q;
  logic       flag_q;
  logic       arm_q;
  logic       inh_q;
  logic       pin_q;

  // compare bytes keep their value through reset
  always_ff @(posedge clk) begin
    if (wr_hi) cmp_hi_q <= wdata;
    if (wr_lo) cmp_lo_q <= wdata;
  end

  assign cmp_val   = {cmp_hi_q, cmp_lo_q};
  assign match_evt = fresh && !inh_q && cnt_hit(cnt, cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     inh_q <= 1'b1;
    else if (wr_hi) inh_q <= 1'b1;
    else if (wr_lo) inh_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 arm_q <= 1'b0;
    else if (wr_lo)             arm_q <= 1'b0;
    else if (rd_stat && flag_q) arm_q <= 1'b1;
  end

  // flag keeps its value through reset
  always_ff @(posedge clk) begin
    if (match_evt)           flag_q <= 1'b1;
    else if (wr_lo && arm_q) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_q <= 1'b0;
    else if (match_evt) pin_q <= lvl_sel;
  end

  assign flag    = flag_q;
  assign pin     = pin_q;
  assign inhibit = inh_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cmp_out,
  output logic              irq
);
  bus_evt_t         evt;
  logic             tick;
  logic             fresh;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_val;
  logic [7:0]       lo_view;
  logic             flag_q;
  logic             inhibit_q;
  logic             match_evt;
  logic             lvl_sel;
  logic             ie_q;

  always_comb begin
    evt           = '0;
    evt.wr_ctrl   = bus_wr && (bus_addr == ADR_CTRL);
    evt.rd_stat   = bus_rd && (bus_addr == ADR_STAT);
    evt.wr_cmp_hi = bus_wr && (bus_addr == ADR_CMPH);
    evt.wr_cmp_lo = bus_wr && (bus_addr == ADR_CMPL);
    evt.rd_cnt_hi = bus_rd && (bus_addr == ADR_CNTH);
    evt.rd_cnt_lo = bus_rd && (bus_addr == ADR_CNTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_sel <= 1'b0;
      ie_q    <= 1'b0;
    end else if (evt.wr_ctrl) begin
      lvl_sel <= bus_wdata[CTRL_LVL_BIT];
      ie_q    <= bus_wdata[CTRL_IE_BIT];
    end
  end

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  tmr_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rd_hi   (evt.rd_cnt_hi),
    .rd_lo   (evt.rd_cnt_lo),
    .cnt     (cnt_q),
    .fresh   (fresh),
    .lo_view (lo_view)
  );

  tmr_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fresh     (fresh),
    .cnt       (cnt_q),
    .wr_hi     (evt.wr_cmp_hi),
    .wr_lo     (evt.wr_cmp_lo),
    .wdata     (bus_wdata),
    .rd_stat   (evt.rd_stat),
    .lvl_sel   (lvl_sel),
    .cmp_val   (cmp_val),
    .flag      (flag_q),
    .pin       (cmp_out),
    .inhibit   (inhibit_q),
    .match_evt (match_evt)
  );

  assign irq = flag_q && ie_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADR_CTRL: begin
          bus_rdata[CTRL_LVL_BIT] = lvl_sel;
          bus_rdata[CTRL_IE_BIT]  = ie_q;
        end
        ADR_STAT: bus_rdata[STAT_FLAG_BIT] = flag_q;
        ADR_CMPH: bus_rdata = cmp_val[15:8];
        ADR_CMPL: bus_rdata = cmp_val[7:0];
        ADR_CNTH: bus_rdata = cnt_q[15:8];
        ADR_CNTL: bus_rdata = lo_view;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              cmp_out,
  input logic              match_evt,
  input logic              flag_q,
  input logic              inhibit_q,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              lvl_sel
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + 16'd1)); // R1

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q); // R3

  AST_MATCH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (cmp_out == $past(lvl_sel))); // R7

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !match_evt |=> $stable(cmp_out)); // R3

  AST_HI_WR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CMPH) |=> inhibit_q); // R4

  AST_LO_WR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CMPL) |=> !inhibit_q); // R5

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt); // R9
endmodule

bind cmp_timer cmp_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .cmp_out   (cmp_out),
  .match_evt (match_evt),
  .flag_q    (flag_q),
  .inhibit_q (inhibit_q),
  .tick      (tick),
  .cnt_q     (cnt_q),
  .lvl_sel   (lvl_sel)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cmp_out;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb[$];
  event     sample_ev;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_out(cmp_out), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the expected read value and compares it with the bus
  always @(sample_ev) begin
    sb_item_t it;
    if (sb.size() != 0) begin
      it = sb.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: read data %02h, expected %02h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  // all bus tasks start just after a falling edge and end just after one
  task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    sb_item_t it;
    bus_rd = 1'b1; bus_addr = a;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #(PERIOD/4) -> sample_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pin(input logic v, input int limit, input string tag, output int at);
    int k = 0;
    while (cmp_out !== v && k < limit) begin
      @(negedge clk);
      k++;
    end
    at = cyc;
    checks++;
    if (cmp_out !== v) begin
      fails++;
      $display("FAIL %s: cmp_out %0b, expected %0b within %0d cycles", tag, cmp_out, v, limit);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t_rise, t_fall, t_dummy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk(cmp_out, 0, "R3 reset level");
    chk(irq, 0, "R6 reset irq");
    bus_read(3'd0, 8'h00, "R11 ctrl after reset");
    bus_read(3'd4, 8'hFF, "R1 counter high at reset");
    idle(5);
    bus_read(3'd5, 8'hFC, "R10 coherent low byte");

    // first match: level 1, interrupt enabled
    bus_write(3'd0, 8'h81);
    bus_write(3'd2, 8'h00);
    bus_write(3'd3, 8'h10);
    wait_pin(1'b1, 400, "R3 rise at match 0010", t_rise);
    chk(irq, 1, "R6 irq with flag and enable");
    bus_read(3'd4, 8'h00, "R1 wrap high byte");
    bus_read(3'd5, 8'h10, "R3 match count low byte");

    // second match with flag still set, low byte only
    bus_write(3'd0, 8'h80);
    bus_write(3'd3, 8'h20);
    wait_pin(1'b0, 400, "R5 low write keeps matching", t_fall);
    chk(cmp_out, 0, "R7 level moves while flag set");
    chk(t_fall - t_rise, 64, "R1 clocks for 16 counts");
    chk(irq, 1, "R8 flag kept without status read");
    bus_read(3'd1, 8'h40, "R8 flag still set");
    bus_read(3'd2, 8'h00, "R2 high byte readback");
    bus_read(3'd3, 8'h20, "R2 low byte readback");
    bus_write(3'd3, 8'h20);
    bus_read(3'd1, 8'h00, "R8 flag cleared by sequence");
    chk(irq, 0, "R6 irq drops with flag");

    // blocked window after a high-byte write
    bus_write(3'd0, 8'h01);
    bus_write(3'd3, 8'h40);
    bus_write(3'd2, 8'h00);
    idle(200);
    chk(cmp_out, 0, "R4 no match while blocked");
    bus_read(3'd1, 8'h00, "R4 flag untouched while blocked");
    bus_write(3'd3, 8'h80);
    wait_pin(1'b1, 800, "R4 matching resumes after low write", t_dummy);

    // same count: clear and rewrite must not re-trigger
    bus_read(3'd1, 8'h40, "R9 flag set at match");
    bus_write(3'd3, 8'h80);
    bus_read(3'd1, 8'h00, "R9 no second match on same count");

    // byte independence and map
    bus_write(3'd2, 8'h12);
    bus_read(3'd3, 8'h80, "R2 low byte kept after high write");
    bus_read(3'd2, 8'h12, "R2 high byte written");
    bus_read(3'd0, 8'h01, "R11 ctrl readback");
    bus_read(3'd6, 8'h00, "R11 unmapped address");
    chk(bus_rdata, 0, "R11 idle read data");
    chk(cmp_out, 1, "R3 level holds between matches");

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule